// File: doc/BRIEF.md
# Receive Character Buffer with Status Mode

This block is the receive-side character store of one serial channel. A deserializer in front of it hands over each received character together with a four-bit error tag. The block keeps the pair in a first-in first-out store of 1023 entries, and a host drains the store through a 16-bit read stream. The read stream works in one of two modes. In packed mode each read carries up to two data bytes. In status mode each read carries one data byte with its error tag in the upper byte.

A sticky status word collects channel-level events: store overflow, two programmable character matches, and break, framing and parity errors. Reading the word clears these events. The same word carries the mode bit and a data-available bit. A programmable fill threshold drives a trigger flag at all times. The interrupt output follows that flag only while the receive interrupt enable is set. A clear strobe empties the store, and the current fill level is always visible on its own port.

The input side carries a valid strobe only and is never stalled: a deserializer cannot hold a character back, so a character that arrives with the store full is discarded and recorded as an overflow. The read side is valid/ready. `rd_valid` is high whenever the store holds a character, and a word is consumed on a cycle where both `rd_valid` and `rd_ready` are high. While a word waits, its low byte does not change. In packed mode, one exception applies: if only one byte is held, the high byte reads 0x00 and may fill in if a second byte arrives before the word is accepted.

Top module: `rx_status_fifo`

## Requirements
- R1: The store holds at most 1023 characters. `fill_count` reports how many it holds, and reset leaves it at 0.
- R2: A character presented while `fill_count` is 1023 is discarded, the count stays at 1023, and status bit 13 (overflow) becomes set.
- R3: A write on `stat_wr` loads `stat_wdata[15]` into the mode bit, which reads back as `status_word[15]` (1 = status mode). The other written bits have no effect.
- R4: In status mode an accepted read returns the oldest byte in `rd_data[7:0]`, its tag in `rd_data[11:8]` and zero in `rd_data[15:12]`, and removes exactly one character. Tag bits are break 3, framing 2, overrun 1, parity 0.
- R5: In packed mode an accepted read returns the oldest byte in `rd_data[7:0]` and the next in `rd_data[15:8]`, and removes two characters. When only one is held, the high byte is 0x00 and one character is removed.
- R6: `rd_valid` is high exactly when the store is not empty. While `rd_ready` is low, nothing is removed and `rd_data[7:0]` holds.
- R7: `trig_sel` selects the trigger threshold: 00 never, 01 at 1 or more characters, 10 at 512 or more, 11 at 896 or more. `trig_flag` is high while the fill level meets the threshold.
- R8: `trig_flag` follows the threshold regardless of `rx_int_en`. `irq` is high only when both `trig_flag` and `rx_int_en` are high.
- R9: Every received character, stored or discarded, sets status bits 10 (break), 9 (framing) and 8 (parity) from tag bits 3, 2 and 0. It also sets bit 11 when `cmp_en[0]` is high and the byte equals `cmp1_val`, and bit 12 when `cmp_en[1]` is high and the byte equals `cmp2_val`.
- R10: A `stat_rd` pulse clears status bits 13:8 on the following cycle. An event in the same cycle as the pulse remains set.
- R11: `status_word[0]` is 1 exactly when data is available. Bits 14 and 7:1 read 0.
- R12: `fifo_clr` empties the store within one cycle. It changes neither the sticky bits nor the mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received character is present this cycle |
| in_data | input | 8 | Received byte |
| in_stat | input | 4 | Error tag of the byte (break, framing, overrun, parity) |
| rd_valid | output | 1 | A read word is available |
| rd_ready | input | 1 | Host accepts the read word |
| rd_data | output | 16 | Read word, packed or status form |
| stat_wr | input | 1 | Write strobe for the mode bit |
| stat_wdata | input | 16 | Write data; bit 15 is the mode |
| stat_rd | input | 1 | Status read strobe; clears sticky bits |
| status_word | output | 16 | Mode, sticky events, data-available |
| trig_sel | input | 2 | Trigger threshold select |
| rx_int_en | input | 1 | Receive interrupt enable |
| trig_flag | output | 1 | Fill threshold reached |
| irq | output | 1 | Interrupt request |
| cmp_en | input | 2 | Match enables (bit 0 first value, bit 1 second) |
| cmp1_val | input | 8 | First match byte |
| cmp2_val | input | 8 | Second match byte |
| fifo_clr | input | 1 | Empty the store |
| fill_count | output | 10 | Characters held |

## Verification
The bound assertions check the following on every cycle:
- the fill level stays within capacity;
- a character arriving on a full store is discarded and marks overflow;
- a status-mode read removes one character and a packed read of a deep store removes two;
- a stalled word keeps its low byte;
- the never-trigger setting and a cleared enable keep `trig_flag` and `irq` low;
- a status read clears the events;
- the clear strobe empties the store.

Only the bench scenarios can show the exact byte order across pointer wrap, the pairing of each byte with its own tag, the precise threshold crossings at 512 and 896, the match flags, and that a clear leaves the sticky state and mode intact.

// File: rtl/rx_status_fifo_pkg.sv
package rx_status_fifo_pkg;

  typedef enum logic [1:0] {
    TRIG_NEVER = 2'b00,
    TRIG_ANY   = 2'b01,
    TRIG_HALF  = 2'b10,
    TRIG_7OF8  = 2'b11
  } trig_sel_e;

  typedef struct packed {
    logic brk;
    logic frm;
    logic ovr;
    logic par;
  } char_tag_t;

  typedef struct packed {
    char_tag_t  tag;
    logic [7:0] data;
  } slot_t;

  localparam int NUM_EVENTS = 6;
  localparam int NUM_CMP    = 2;

endpackage

// File: rtl/rx_status_fifo_store.sv
module rx_status_fifo_store
  import rx_status_fifo_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  slot_t         wr_slot,
  input  logic          pop,
  input  logic          pop_two,
  output slot_t         head0,
  output slot_t         head1,
  output logic [AW-1:0] level
);
  localparam int DEPTH = 1 << AW;

  slot_t         mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;
  logic [AW-1:0] step;
  logic [AW-1:0] add;

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp] <= wr_slot;
  end

  assign head0 = mem[rp];
  assign head1 = mem[rp + AW'(1)];

  always_comb begin
    step = '0;
    if (pop) step = pop_two ? AW'(2) : AW'(1);
    add = push ? AW'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      wp    <= wp + add;
      rp    <= rp + step;
      level <= level + add - step;
    end
  end

endmodule

// File: rtl/rx_status_fifo_trig.sv
module rx_status_fifo_trig
  import rx_status_fifo_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [AW-1:0] level,
  input  trig_sel_e     sel,
  output logic          hit
);
  localparam logic [AW-1:0] LVL_HALF = AW'(1 << (AW - 1));
  localparam logic [AW-1:0] LVL_7OF8 = AW'(7 << (AW - 3));

  always_comb begin
    unique case (sel)
      TRIG_NEVER: hit = 1'b0;
      TRIG_ANY:   hit = (level != '0);
      TRIG_HALF:  hit = (level >= LVL_HALF);
      TRIG_7OF8:  hit = (level >= LVL_7OF8);
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/rx_status_fifo_sticky.sv
module rx_status_fifo_sticky #(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic          rd_clr,
  output logic [NF-1:0] q
);
  for (genvar i = 0; i < NF; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= set[i] | (q[i] & ~rd_clr);
    end
  end

endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
  import rx_status_fifo_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic [3:0]    in_stat,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [15:0]   rd_data,
  input  logic          stat_wr,
  input  logic [15:0]   stat_wdata,
  input  logic          stat_rd,
  output logic [15:0]   status_word,
  input  logic [1:0]    trig_sel,
  input  logic          rx_int_en,
  output logic          trig_flag,
  output logic          irq,
  input  logic [1:0]    cmp_en,
  input  logic [7:0]    cmp1_val,
  input  logic [7:0]    cmp2_val,
  input  logic          fifo_clr,
  output logic [AW-1:0] fill_count
);
  localparam int CAP = (1 << AW) - 1;

  slot_t                 head0;
  slot_t                 head1;
  slot_t                 wr_slot;
  logic                  full;
  logic                  push;
  logic                  drop;
  logic                  rd_fire;
  logic                  pop_two;
  logic                  mode_q;
  logic [NUM_CMP-1:0]    match;
  logic [7:0]            cmp_vals [NUM_CMP];
  logic [NUM_EVENTS-1:0] ev_set;
  logic [NUM_EVENTS-1:0] ev_q;

  assign full     = (fill_count == AW'(CAP));
  assign push     = in_valid & ~full;
  assign drop     = in_valid & full;
  assign rd_valid = (fill_count != '0);
  assign rd_fire  = rd_valid & rd_ready;
  assign pop_two  = ~mode_q & (fill_count >= AW'(2));
  assign wr_slot  = '{tag: char_tag_t'(in_stat), data: in_data};

  rx_status_fifo_store #(.AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (fifo_clr),
    .push    (push),
    .wr_slot (wr_slot),
    .pop     (rd_fire),
    .pop_two (pop_two),
    .head0   (head0),
    .head1   (head1),
    .level   (fill_count)
  );

  // read word: status form pairs one byte with its tag, packed form takes two bytes
  always_comb begin
    if (mode_q) rd_data = {4'h0, head0.tag, head0.data};
    else        rd_data = {(pop_two ? head1.data : 8'h00), head0.data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (stat_wr) mode_q <= stat_wdata[15];
  end

  assign cmp_vals[0] = cmp1_val;
  assign cmp_vals[1] = cmp2_val;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    assign match[k] = in_valid & cmp_en[k] & (in_data == cmp_vals[k]);
  end

  // event order, high to low: overflow, match2, match1, break, framing, parity
  assign ev_set = {drop, match[1], match[0],
                   in_valid & in_stat[3], in_valid & in_stat[2], in_valid & in_stat[0]};

  rx_status_fifo_sticky #(.NF(NUM_EVENTS)) u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (ev_set),
    .rd_clr (stat_rd),
    .q      (ev_q)
  );

  assign status_word = {mode_q, 1'b0, ev_q, 7'b0, rd_valid};

  rx_status_fifo_trig #(.AW(AW)) u_trig (
    .level (fill_count),
    .sel   (trig_sel_e'(trig_sel)),
    .hit   (trig_flag)
  );

  assign irq = trig_flag & rx_int_en;

endmodule

// File: rtl/rx_status_fifo_chk.sv
module rx_status_fifo_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [15:0]   rd_data,
  input logic          stat_rd,
  input logic [15:0]   status_word,
  input logic [1:0]    trig_sel,
  input logic          rx_int_en,
  input logic          trig_flag,
  input logic          irq,
  input logic          fifo_clr,
  input logic [AW-1:0] fill_count
);
  localparam logic [AW-1:0] CAP = AW'((1 << AW) - 1);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CAP); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && fill_count == CAP && !(rd_valid && rd_ready) && !fifo_clr
    |=> fill_count == CAP && status_word[13]); // R2

  AST_STATUS_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[15] && rd_valid && rd_ready && !in_valid && !fifo_clr
    |=> fill_count == $past(fill_count) - AW'(1)); // R4

  AST_PACKED_POP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    !status_word[15] && rd_valid && rd_ready && fill_count >= AW'(2) && !in_valid && !fifo_clr
    |=> fill_count == $past(fill_count) - AW'(2)); // R5

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !fifo_clr
    |=> rd_valid && $stable(rd_data[7:0])); // R6

  AST_TRIG_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    trig_sel == 2'b00 |-> !trig_flag); // R7

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_int_en |-> !irq); // R8

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !in_valid |=> status_word[13:8] == 6'h00); // R10

  AST_AVAIL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[0] == (fill_count != '0)); // R11

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> fill_count == '0 && !rd_valid); // R12

endmodule

bind rx_status_fifo rx_status_fifo_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_data     (rd_data),
  .stat_rd     (stat_rd),
  .status_word (status_word),
  .trig_sel    (trig_sel),
  .rx_int_en   (rx_int_en),
  .trig_flag   (trig_flag),
  .irq         (irq),
  .fifo_clr    (fifo_clr),
  .fill_count  (fill_count)
);

// File: tb/rx_status_fifo_tb.sv
`timescale 1ns/1ps
module rx_status_fifo_tb;
  localparam int AW  = 10;
  localparam int CAP = 1023;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic [3:0]    in_stat = '0;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [15:0]   rd_data;
  logic          stat_wr = 1'b0;
  logic [15:0]   stat_wdata = '0;
  logic          stat_rd = 1'b0;
  logic [15:0]   status_word;
  logic [1:0]    trig_sel = 2'b00;
  logic          rx_int_en = 1'b0;
  logic          trig_flag;
  logic          irq;
  logic [1:0]    cmp_en = 2'b00;
  logic [7:0]    cmp1_val = '0;
  logic [7:0]    cmp2_val = '0;
  logic          fifo_clr = 1'b0;
  logic [AW-1:0] fill_count;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  bit  smode = 1'b0;
  byte unsigned     qd[$];
  logic [3:0]       qs[$];

  always #4 clk = ~clk;

  rx_status_fifo #(.AW(AW)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  endtask

  // driver: one character per cycle; model queue takes it only if room
  task automatic put(input logic [7:0] d, input logic [3:0] s);
    in_valid = 1'b1; in_data = d; in_stat = s;
    if (qd.size() < CAP) begin qd.push_back(d); qs.push_back(s); end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic read_words(input int n);
    rd_ready = 1'b1;
    repeat (n) @(posedge clk);
    #1 rd_ready = 1'b0;
  endtask

  task automatic set_mode(input bit m);
    stat_wr = 1'b1; stat_wdata = {m, 15'h7fff};
    @(posedge clk); #1;
    stat_wr = 1'b0; smode = m;
  endtask

  task automatic rd_stat(output logic [15:0] w);
    stat_rd = 1'b1; w = status_word;
    @(posedge clk); #1;
    stat_rd = 1'b0;
  endtask

  // monitor: compares each accepted word against the model queue
  always @(negedge clk) begin
    if (rst_n && rd_ready) begin : mon
      logic [15:0] exp_w;
      if (qd.size() == 0) begin
        chk(!rd_valid, "R6 valid with empty model", 32'(rd_valid), 0);
      end else if (smode) begin
        exp_w = {4'h0, qs[0], qd[0]};
        chk(rd_valid && rd_data == exp_w, "R4 status word", 32'(rd_data), 32'(exp_w));
        void'(qd.pop_front()); void'(qs.pop_front());
      end else begin
        if (qd.size() >= 2) begin
          exp_w = {qd[1], qd[0]};
          void'(qd.pop_front()); void'(qs.pop_front());
        end else exp_w = {8'h00, qd[0]};
        chk(rd_valid && rd_data == exp_w, "R5 packed word", 32'(rd_data), 32'(exp_w));
        void'(qd.pop_front()); void'(qs.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    report();
  end

  initial begin
    logic [15:0] w;
    logic [15:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    chk(fill_count == 0, "R1 reset count", 32'(fill_count), 0);
    chk(!rd_valid, "R6 reset valid", 32'(rd_valid), 0);
    chk(status_word == 16'h0000, "R11 reset status", 32'(status_word), 0);
    chk(!trig_flag && !irq, "R8 reset trigger", {trig_flag, irq}, 0);

    // status mode: byte paired with tag
    set_mode(1'b1);
    chk(status_word[15] && status_word[13:8] == 0, "R3 mode bit", 32'(status_word), 32'h8000);
    put(8'hA1, 4'b0001);
    put(8'hB2, 4'b1000);
    put(8'hC3, 4'b0110);
    chk(fill_count == 3, "R1 count three", 32'(fill_count), 3);
    chk(status_word[0] == 1'b1, "R11 data available", 32'(status_word[0]), 1);
    rd_stat(w);
    chk(w[13:8] == 6'h07, "R9 break framing parity", 32'(w[13:8]), 32'h07);
    read_words(3);
    chk(fill_count == 0 && status_word[0] == 1'b0, "R11 drained", 32'(status_word), 32'h8000);
    rd_stat(w);
    chk(w[13:8] == 6'h00, "R10 cleared on read", 32'(w[13:8]), 0);

    // packed mode: 5 bytes in 3 reads
    set_mode(1'b0);
    chk(status_word[15] == 1'b0, "R3 mode off", 32'(status_word[15]), 0);
    for (int i = 0; i < 5; i++) put(8'(8'h10 + i), 4'h0);
    read_words(3);
    chk(fill_count == 0, "R5 odd count drained", 32'(fill_count), 0);

    // back-pressure
    put(8'h21, 4'h0);
    put(8'h22, 4'h0);
    held = rd_data;
    repeat (3) @(posedge clk);
    #1;
    chk(rd_valid && rd_data == held && fill_count == 2, "R6 stall holds", 32'(rd_data), 32'(held));
    read_words(1);
    chk(fill_count == 0, "R6 stall released", 32'(fill_count), 0);

    // match events
    cmp1_val = 8'h7E; cmp2_val = 8'h33; cmp_en = 2'b01;
    put(8'h7E, 4'h0);
    put(8'h33, 4'h0);
    rd_stat(w);
    chk(w[13:8] == 6'h08, "R9 match one only", 32'(w[13:8]), 32'h08);
    cmp_en = 2'b10;
    put(8'h33, 4'h0);
    rd_stat(w);
    chk(w[13:8] == 6'h10, "R9 match two", 32'(w[13:8]), 32'h10);
    cmp_en = 2'b00;
    read_words(2);
    // event in the same cycle as a status read survives
    stat_rd = 1'b1;
    put(8'h44, 4'b0001);
    stat_rd = 1'b0;
    rd_stat(w);
    chk(w[13:8] == 6'h01, "R10 set wins over clear", 32'(w[13:8]), 32'h01);
    read_words(1);

    // trigger and interrupt gating
    trig_sel = 2'b01; rx_int_en = 1'b0;
    #1 chk(!trig_flag, "R7 any on empty", 32'(trig_flag), 0);
    put(8'h55, 4'h0);
    chk(trig_flag && !irq, "R8 flag without enable", {trig_flag, irq}, 32'h2);
    rx_int_en = 1'b1;
    #1 chk(irq, "R8 irq with enable", 32'(irq), 1);
    trig_sel = 2'b00;
    #1 chk(!trig_flag && !irq, "R7 never", {trig_flag, irq}, 0);
    read_words(1);
    rx_int_en = 1'b0;

    // fill to capacity with threshold crossings
    trig_sel = 2'b10;
    for (int i = 0; i < CAP; i++) begin
      put(8'(i) ^ 8'hA5, 4'h0);
      if (i + 1 == 511) chk(!trig_flag, "R7 half below", 32'(trig_flag), 0);
      if (i + 1 == 512) chk(trig_flag, "R7 half reached", 32'(trig_flag), 1);
      if (i + 1 == 600) trig_sel = 2'b11;
      if (i + 1 == 895) begin #1 chk(!trig_flag, "R7 seven-eighths below", 32'(trig_flag), 0); end
      if (i + 1 == 896) chk(trig_flag, "R7 seven-eighths reached", 32'(trig_flag), 1);
    end
    chk(fill_count == 10'(CAP), "R1 full count", 32'(fill_count), CAP);
    put(8'hEE, 4'h0);
    chk(fill_count == 10'(CAP) && status_word[13], "R2 drop on full", 32'(status_word), 32'h2001);

    // partial drain, refill across pointer wrap, full drain
    read_words(300);
    chk(fill_count == 10'(CAP - 600), "R5 partial drain", 32'(fill_count), CAP - 600);
    for (int i = 0; i < 500; i++) put(8'(i + 7), 4'h0);
    read_words(462);
    chk(fill_count == 0 && !rd_valid, "R6 wrap drained", 32'(fill_count), 0);
    rd_stat(w);
    chk(w[13:8] == 6'h20, "R2 overflow sticky", 32'(w[13:8]), 32'h20);

    // clear keeps sticky state and mode
    set_mode(1'b1);
    put(8'h01, 4'b0001);
    put(8'h02, 4'h0);
    fifo_clr = 1'b1;
    @(posedge clk); #1;
    fifo_clr = 1'b0;
    qd.delete(); qs.delete();
    chk(fill_count == 0 && !rd_valid, "R12 clear empties", 32'(fill_count), 0);
    chk(status_word[15] && status_word[8], "R12 clear keeps status", 32'(status_word), 32'h8100);
    put(8'h99, 4'h0);
    read_words(1);
    chk(fill_count == 0, "R12 restart after clear", 32'(fill_count), 0);

    report();
  end

endmodule